// File: doc/BRIEF.md
# Card Command Response Status Unit

This unit sits between a host-written command register and a memory-card command engine. When the host writes a command word and the controller is enabled, the unit decodes the word into its fields. It latches the command argument and raises a one-cycle request toward the card port. It then waits for the card port to deliver a response: a byte count and a 16-byte response buffer.

When the response arrives, the unit classifies it by the response type in the command word. A reply that is too short counts as a timeout. The unit checks the card's error bits against a mask chosen by the response type. It records completion, timeout, error and power-up-busy indications in a sticky status register, which the host clears by writing ones. Valid responses are packed into eight 16-bit response registers in reversed word order. Commands that move data arm the downstream transfer engine with a direction and a FIFO reset pulse.

Top module: `cmd_rsp_unit`

## Requirements
- R1: An accepted command write produces `card_req_o` high for exactly one cycle, starting on the clock edge that accepts the write. While it is high, `card_idx_o` equals word bits 5:0, `card_init_o` equals bit 7, and `card_arg_o` equals `arg_i` as sampled at the write.
- R2: A command write is accepted only when `enable_i` is 1 and no earlier command is still waiting for its response. Any other command write has no effect.
- R3: On the edge that accepts a command, all eight response registers are cleared to zero.
- R4: Response type codes are in word bits 10:8. Codes 1, 3 and 6 need at least 4 response bytes; code 2 needs 16. A shorter reply sets status bit 7 (timeout). Codes 0, 4, 5 and 7 expect no response: they never time out and never load the response registers.
- R5: When there is no timeout, a response sets status bit 0. If the command index is 12, it sets status bits 0 and 2. A timeout sets neither bit.
- R6: Byte i of the response is `card_rsp_data_i[8i+7:8i]`. The checked word is bytes 0..3 taken big-endian, with byte 0 as bits 31:24. Type 1 sets status bit 14 if this word ANDed with 0xFDF90000 is nonzero. Type 6 sets bit 14 if the 16-bit value {byte 2, byte 3} ANDed with 0xE008 is nonzero. No other type, and no timed-out reply, sets bit 14.
- R7: For type 3 without a timeout, status bit 12 is set when bit 31 of the checked word (bit 7 of byte 0) is 0.
- R8: The command kind is in word bits 13:12. Kind 3 (addressed data transfer) pulses `fifo_rst_o` together with `card_req_o`, sets `xfer_active_o`, and latches bit 15 into `xfer_dir_o`. Any other kind clears `xfer_active_o` and leaves `xfer_dir_o` unchanged.
- R9: `card_busy_o` is 1 exactly when the pending command has response type 1 and busy bit 11 set. The status outcome of this busy variant is the same as for type 1.
- R10: On a response without timeout, for a type that expects a response, response register 7−k gets {byte 2k, byte 2k+1} for k = 0..7. Register j is `rsp_o[16j+15:16j]`.
- R11: Status bits are sticky. A write to the status-clear port clears the bits it marks with ones. A bit that is cleared and set in the same cycle ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Controller enable; gates command acceptance |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_word_i | input | 16 | Command word |
| arg_i | input | 32 | Command argument, latched at acceptance |
| stat_clr_we_i | input | 1 | Status clear strobe |
| stat_clr_i | input | 16 | Write-one-to-clear mask for status |
| card_rsp_valid_i | input | 1 | Card port response valid |
| card_rsp_len_i | input | 5 | Number of response bytes returned |
| card_rsp_data_i | input | 128 | Response bytes, byte i at bits 8i+7:8i |
| card_req_o | output | 1 | One-cycle command request to the card port |
| card_idx_o | output | 6 | Command index |
| card_init_o | output | 1 | Initialisation-sequence flag |
| card_busy_o | output | 1 | Busy-variant normal response expected |
| card_arg_o | output | 32 | Latched command argument |
| cmd_pending_o | output | 1 | Command waiting for its response |
| status_o | output | 16 | Sticky status register |
| rsp_o | output | 128 | Eight packed 16-bit response registers |
| xfer_active_o | output | 1 | Data transfer armed |
| xfer_dir_o | output | 1 | Data transfer direction |
| fifo_rst_o | output | 1 | One-cycle FIFO pointer reset pulse |

## Verification
A wrong length rule or error mask shows up in `status_o` one edge after the response strobe, as a missing or extra timeout or error bit. A wrong byte order in the packer shows up in `rsp_o` at that same edge. A broken pending lock or enable gate shows up as an extra `card_req_o` pulse, or a changed `card_idx_o`, on the edge after the offending write. Every combination of response type, busy flag, reply length and error pattern is run. This exposes wrong cases in the type classification within a single command.

// File: rtl/cmd_rsp_pkg.sv
package cmd_rsp_pkg;

    localparam int RSP_BYTES = 16;
    localparam int RSP_WORDS = RSP_BYTES / 2;
    localparam int STAT_W    = 16;
    localparam int LEN_W     = $clog2(RSP_BYTES) + 1;

    // response type codes
    localparam logic [2:0] RT_NONE  = 3'd0;
    localparam logic [2:0] RT_SHORT = 3'd1;
    localparam logic [2:0] RT_LONG  = 3'd2;
    localparam logic [2:0] RT_OCR   = 3'd3;
    localparam logic [2:0] RT_RCA   = 3'd6;

    localparam logic [31:0] SHORT_ERR_MASK = 32'hFDF9_0000;
    localparam logic [15:0] RCA_ERR_MASK   = 16'hE008;
    localparam logic [5:0]  STOP_IDX       = 6'd12;

    // status bit positions
    localparam int ST_DONE = 0;
    localparam int ST_STOP = 2;
    localparam int ST_TMO  = 7;
    localparam int ST_PWR  = 12;
    localparam int ST_CERR = 14;

    typedef enum logic [1:0] {
        CK_BCAST  = 2'd0,
        CK_BCAST_R = 2'd1,
        CK_ADDR   = 2'd2,
        CK_DATA   = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        logic      dir;
        cmd_kind_e kind;
        logic      busy;
        logic [2:0] rtype;
        logic      init;
        logic [5:0] idx;
    } cmd_fields_t;

    function automatic cmd_fields_t split_cmd(input logic [15:0] w);
        cmd_fields_t f;
        f.dir   = w[15];
        f.kind  = cmd_kind_e'(w[13:12]);
        f.busy  = w[11];
        f.rtype = w[10:8];
        f.init  = w[7];
        f.idx   = w[5:0];
        return f;
    endfunction

endpackage

// File: rtl/cmd_rsp_eval.sv
module cmd_rsp_eval
    import cmd_rsp_pkg::*;
(
    input  logic [2:0]        rtype_i,
    input  logic [5:0]        idx_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [31:0]       head_i,
    output logic [STAT_W-1:0] set_o,
    output logic              pack_o
);
    logic [31:0]      word;
    logic             known;
    logic             tmo;
    logic             err;
    logic [LEN_W-1:0] need;

    always_comb begin
        word  = {head_i[7:0], head_i[15:8], head_i[23:16], head_i[31:24]};
        known = (rtype_i == RT_SHORT) || (rtype_i == RT_LONG) ||
                (rtype_i == RT_OCR)   || (rtype_i == RT_RCA);
        need  = (rtype_i == RT_LONG) ? LEN_W'(RSP_BYTES) : LEN_W'(4);
        tmo   = known && (len_i < need);
        err   = 1'b0;
        if (!tmo) begin
            if (rtype_i == RT_SHORT)
                err = |(word & SHORT_ERR_MASK);
            else if (rtype_i == RT_RCA)
                err = |(word[15:0] & RCA_ERR_MASK);
        end
        set_o = '0;
        if (tmo) begin
            set_o[ST_TMO] = 1'b1;
        end else begin
            set_o[ST_DONE] = 1'b1;
            set_o[ST_STOP] = (idx_i == STOP_IDX);
            set_o[ST_CERR] = err;
            set_o[ST_PWR]  = (rtype_i == RT_OCR) && !word[31];
        end
        pack_o = known && !tmo;
    end
endmodule

// File: rtl/cmd_rsp_pack.sv
module cmd_rsp_pack #(
    parameter int WORDS = 8
) (
    input  logic [WORDS*16-1:0] bytes_i,
    output logic [WORDS*16-1:0] regs_o
);
    for (genvar k = 0; k < WORDS; k++) begin : g_word
        assign regs_o[(WORDS-1-k)*16 +: 16] = {bytes_i[16*k +: 8], bytes_i[16*k+8 +: 8]};
    end
endmodule

// File: rtl/cmd_rsp_unit.sv
module cmd_rsp_unit
    import cmd_rsp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable_i,
    input  logic                   cmd_we_i,
    input  logic [15:0]            cmd_word_i,
    input  logic [31:0]            arg_i,
    input  logic                   stat_clr_we_i,
    input  logic [STAT_W-1:0]      stat_clr_i,
    input  logic                   card_rsp_valid_i,
    input  logic [LEN_W-1:0]       card_rsp_len_i,
    input  logic [RSP_BYTES*8-1:0] card_rsp_data_i,
    output logic                   card_req_o,
    output logic [5:0]             card_idx_o,
    output logic                   card_init_o,
    output logic                   card_busy_o,
    output logic [31:0]            card_arg_o,
    output logic                   cmd_pending_o,
    output logic [STAT_W-1:0]      status_o,
    output logic [RSP_WORDS*16-1:0] rsp_o,
    output logic                   xfer_active_o,
    output logic                   xfer_dir_o,
    output logic                   fifo_rst_o
);
    cmd_fields_t              dec;
    cmd_fields_t              cmd_q;
    logic                     pending_q;
    logic                     req_q;
    logic                     fifo_rst_q;
    logic                     xfer_act_q;
    logic                     xfer_dir_q;
    logic [31:0]              arg_q;
    logic [STAT_W-1:0]        status_q;
    logic [RSP_WORDS*16-1:0]  rsp_q;
    logic [STAT_W-1:0]        set_bits;
    logic                     pack_en;
    logic [RSP_WORDS*16-1:0]  packed_w;
    logic                     accept;
    logic                     take;
    logic [STAT_W-1:0]        clr_mask;

    assign dec      = split_cmd(cmd_word_i);
    assign accept   = cmd_we_i && enable_i && !pending_q;
    assign take     = card_rsp_valid_i && pending_q;
    assign clr_mask = stat_clr_we_i ? stat_clr_i : '0;

    cmd_rsp_eval u_eval (
        .rtype_i (cmd_q.rtype),
        .idx_i   (cmd_q.idx),
        .len_i   (card_rsp_len_i),
        .head_i  (card_rsp_data_i[31:0]),
        .set_o   (set_bits),
        .pack_o  (pack_en)
    );

    cmd_rsp_pack #(.WORDS(RSP_WORDS)) u_pack (
        .bytes_i (card_rsp_data_i),
        .regs_o  (packed_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= '0;
            pending_q  <= 1'b0;
            req_q      <= 1'b0;
            fifo_rst_q <= 1'b0;
            xfer_act_q <= 1'b0;
            xfer_dir_q <= 1'b0;
            arg_q      <= '0;
            status_q   <= '0;
            rsp_q      <= '0;
        end else begin
            req_q      <= accept;
            fifo_rst_q <= accept && (dec.kind == CK_DATA);
            status_q   <= (status_q & ~clr_mask) | (take ? set_bits : '0);
            if (accept) begin
                pending_q  <= 1'b1;
                cmd_q      <= dec;
                arg_q      <= arg_i;
                rsp_q      <= '0;
                xfer_act_q <= (dec.kind == CK_DATA);
                if (dec.kind == CK_DATA)
                    xfer_dir_q <= dec.dir;
            end else if (take) begin
                pending_q <= 1'b0;
                if (pack_en)
                    rsp_q <= packed_w;
            end
        end
    end

    assign card_req_o    = req_q;
    assign card_idx_o    = cmd_q.idx;
    assign card_init_o   = cmd_q.init;
    assign card_busy_o   = (cmd_q.rtype == RT_SHORT) && cmd_q.busy;
    assign card_arg_o    = arg_q;
    assign cmd_pending_o = pending_q;
    assign status_o      = status_q;
    assign rsp_o         = rsp_q;
    assign xfer_active_o = xfer_act_q;
    assign xfer_dir_o    = xfer_dir_q;
    assign fifo_rst_o    = fifo_rst_q;
endmodule

// File: rtl/cmd_rsp_unit_chk.sv
module cmd_rsp_unit_chk
    import cmd_rsp_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    enable_i,
    input logic                    cmd_we_i,
    input logic                    card_rsp_valid_i,
    input logic [LEN_W-1:0]        card_rsp_len_i,
    input logic                    card_req_o,
    input logic [RSP_WORDS*16-1:0] rsp_o,
    input logic [STAT_W-1:0]       status_o,
    input logic                    fifo_rst_o,
    input logic                    pending,
    input logic [2:0]              rtype
);
    // R2
    disabled_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we_i && !enable_i) |=> !card_req_o);

    // R3
    rsp_clear_chk: assert property (@(posedge clk) disable iff (rst)
        card_req_o |-> (rsp_o == '0));

    // R1
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        card_req_o |=> !card_req_o);

    // R4
    long_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        (card_rsp_valid_i && pending && rtype == RT_LONG &&
         card_rsp_len_i < LEN_W'(RSP_BYTES)) |=> status_o[ST_TMO]);

    // R5
    completion_chk: assert property (@(posedge clk) disable iff (rst)
        (card_rsp_valid_i && pending) |=> (status_o[ST_DONE] || status_o[ST_TMO]));

    // R8
    fifo_rst_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rst_o |-> card_req_o);
endmodule

bind cmd_rsp_unit cmd_rsp_unit_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .enable_i         (enable_i),
    .cmd_we_i         (cmd_we_i),
    .card_rsp_valid_i (card_rsp_valid_i),
    .card_rsp_len_i   (card_rsp_len_i),
    .card_req_o       (card_req_o),
    .rsp_o            (rsp_o),
    .status_o         (status_o),
    .fifo_rst_o       (fifo_rst_o),
    .pending          (pending_q),
    .rtype            (cmd_q.rtype)
);

// File: tb/cmd_rsp_unit_tb.sv
module cmd_rsp_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         enable_i = 1'b0;
    logic         cmd_we_i = 1'b0;
    logic [15:0]  cmd_word_i = '0;
    logic [31:0]  arg_i = '0;
    logic         stat_clr_we_i = 1'b0;
    logic [15:0]  stat_clr_i = '0;
    logic         card_rsp_valid_i = 1'b0;
    logic [4:0]   card_rsp_len_i = '0;
    logic [127:0] card_rsp_data_i = '0;
    logic         card_req_o, card_init_o, card_busy_o, cmd_pending_o;
    logic [5:0]   card_idx_o;
    logic [31:0]  card_arg_o;
    logic [15:0]  status_o;
    logic [127:0] rsp_o;
    logic         xfer_active_o, xfer_dir_o, fifo_rst_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5ns clk = ~clk;

    cmd_rsp_unit dut_i (.*);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_word(input bit dir, input int kind, input bit busy,
                                            input int rt, input bit init, input int idx);
        return {dir, 1'b0, kind[1:0], busy, rt[2:0], init, 1'b0, idx[5:0]};
    endfunction

    function automatic logic [15:0] exp_stat(input int rt, input int idx, input int len,
                                             input logic [127:0] d);
        logic [15:0] s = '0;
        logic [31:0] w = {d[7:0], d[15:8], d[23:16], d[31:24]};
        bit known = (rt == 1 || rt == 2 || rt == 3 || rt == 6);
        int need = (rt == 2) ? 16 : 4;
        if (known && len < need) begin
            s[7] = 1'b1;
        end else begin
            s[0] = 1'b1;
            if (idx == 12) s[2] = 1'b1;
            if (rt == 1 && (w & 32'hFDF90000) != 0) s[14] = 1'b1;
            if (rt == 6 && (w[15:0] & 16'hE008) != 0) s[14] = 1'b1;
            if (rt == 3 && !w[31]) s[12] = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [127:0] exp_rsp(input int rt, input int len, input logic [127:0] d);
        logic [127:0] r = '0;
        bit known = (rt == 1 || rt == 2 || rt == 3 || rt == 6);
        int need = (rt == 2) ? 16 : 4;
        if (known && len >= need)
            for (int k = 0; k < 8; k++)
                r[(7-k)*16 +: 16] = {d[16*k +: 8], d[16*k+8 +: 8]};
        return r;
    endfunction

    task automatic issue(input logic [15:0] w, input logic [31:0] a);
        @(negedge clk);
        cmd_word_i = w; arg_i = a; cmd_we_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_we_i = 1'b0;
    endtask

    task automatic respond(input int len, input logic [127:0] d);
        card_rsp_valid_i = 1'b1; card_rsp_len_i = len[4:0]; card_rsp_data_i = d;
        @(posedge clk);
        @(negedge clk);
        card_rsp_valid_i = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        stat_clr_we_i = 1'b1; stat_clr_i = 16'hFFFF;
        @(posedge clk);
        @(negedge clk);
        stat_clr_we_i = 1'b0;
    endtask

    initial begin
        #2_000_000ns;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] pat [2];
        int lens [4] = '{3, 4, 15, 16};
        for (int i = 0; i < 16; i++) begin
            pat[0][8*i +: 8] = (i < 4) ? 8'h00 : 8'(i * 17);
            pat[1][8*i +: 8] = (i == 0) ? 8'hFF : 8'(i * 17 + 1);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R1 reset req", {127'b0, card_req_o}, 128'd0);
        chk("R11 reset status", {112'b0, status_o}, 128'd0);
        chk("R10 reset rsp", rsp_o, 128'd0);
        chk("R8 reset xfer", {126'b0, xfer_active_o, fifo_rst_o}, 128'd0);

        // R2 disabled write ignored
        issue(mk_word(0, 2, 0, 1, 0, 7), 32'h1);
        chk("R2 disabled no req", {127'b0, card_req_o}, 128'd0);
        chk("R2 disabled not pending", {127'b0, cmd_pending_o}, 128'd0);
        enable_i = 1'b1;

        // R1 fields and argument
        issue(mk_word(0, 2, 0, 1, 1, 41), 32'hCAFE_1234);
        chk("R1 req pulse", {127'b0, card_req_o}, 128'd1);
        chk("R1 idx", {122'b0, card_idx_o}, 128'd41);
        chk("R1 init", {127'b0, card_init_o}, 128'd1);
        chk("R1 arg", {96'b0, card_arg_o}, {96'b0, 32'hCAFE_1234});
        // R2 write while pending ignored
        issue(mk_word(0, 2, 0, 1, 0, 9), 32'h5);
        chk("R1 pulse ends", {127'b0, card_req_o}, 128'd0);
        chk("R2 pending write ignored idx", {122'b0, card_idx_o}, 128'd41);
        chk("R2 pending write ignored arg", {96'b0, card_arg_o}, {96'b0, 32'hCAFE_1234});
        respond(4, pat[0]);
        chk("R5 first done", {112'b0, status_o}, {112'b0, exp_stat(1, 41, 4, pat[0])});

        // R8 data command
        issue(mk_word(1, 3, 0, 1, 0, 17), 32'h0);
        chk("R8 fifo reset pulse", {127'b0, fifo_rst_o}, 128'd1);
        chk("R8 active", {127'b0, xfer_active_o}, 128'd1);
        chk("R8 dir", {127'b0, xfer_dir_o}, 128'd1);
        respond(4, pat[0]);
        chk("R8 fifo reset ends", {127'b0, fifo_rst_o}, 128'd0);
        issue(mk_word(0, 2, 0, 1, 0, 13), 32'h0);
        chk("R8 non-data clears active", {127'b0, xfer_active_o}, 128'd0);
        chk("R8 dir held", {127'b0, xfer_dir_o}, 128'd1);
        chk("R8 no fifo reset", {127'b0, fifo_rst_o}, 128'd0);

        // R11 set wins over clear, selective clear
        clear_all();
        card_rsp_valid_i = 1'b1; card_rsp_len_i = 5'd4; card_rsp_data_i = pat[1];
        stat_clr_we_i = 1'b1; stat_clr_i = 16'h0001;
        @(posedge clk);
        @(negedge clk);
        card_rsp_valid_i = 1'b0; stat_clr_we_i = 1'b0;
        chk("R11 set wins", {112'b0, status_o}, {112'b0, 16'h4001});
        stat_clr_we_i = 1'b1; stat_clr_i = 16'h0001;
        @(posedge clk);
        @(negedge clk);
        stat_clr_we_i = 1'b0;
        chk("R11 selective clear", {112'b0, status_o}, {112'b0, 16'h4000});

        // sweep all types, busy, lengths, patterns
        for (int rt = 0; rt < 8; rt++)
            for (int b = 0; b < 2; b++)
                for (int li = 0; li < 4; li++)
                    for (int p = 0; p < 2; p++) begin
                        int idx = ((rt + li + p) % 2 == 1) ? 12 : 5;
                        clear_all();
                        issue(mk_word(0, 2, b[0], rt, 0, idx), 32'h0);
                        chk("R3 rsp cleared", rsp_o, 128'd0);
                        chk("R9 busy variant", {127'b0, card_busy_o},
                            {127'b0, (rt == 1 && b == 1)});
                        respond(lens[li], pat[p]);
                        chk("R4 R5 R6 R7 status", {112'b0, status_o},
                            {112'b0, exp_stat(rt, idx, lens[li], pat[p])});
                        chk("R10 packing", rsp_o, exp_rsp(rt, lens[li], pat[p]));
                    end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule